// File: doc/BRIEF.md
# SMRAM Lock and Protected Segment Filter

This block sits in a host bridge and guards a protected memory segment at the top of installed DRAM. It holds two byte-wide configuration registers: a main control byte (open, closed, lock and global enable bits) and an extended control byte (segment size code and segment enable). From these it works out where the protected segment starts. It then classifies every processor memory access presented on its check port as either passed through or blocked.

A blocked access comes from outside system-management mode and targets the closed segment. A blocked read returns forced all-ones data, and a blocked write must be dropped by the memory path. Once software sets the lock bit, the open bit is forced low and stays low. The enable bits and the size code also become read-only, so the window cannot be moved or reopened. Only a system reset releases the lock. The extended segment size comes from a static input that is captured while reset is held.

Top module: `smram_guard`

## Requirements
- R1: After reset both configuration registers read 0x00. Main byte layout: bit 6 open, bit 5 closed, bit 4 lock, bit 3 global enable, all other bits read 0. Extended byte layout: bits 2:1 size code, bit 0 segment enable, bits 7:3 read 0. `cfg_sel`=0 selects the main byte and `cfg_sel`=1 selects the extended byte.
- R2: While unlocked, a write to the main byte sets or clears the open bit, and a readback returns the written value.
- R3: A write that sets the lock bit forces the open bit to 0 in the same update, whatever value was written to bit 6.
- R4: The lock bit is sticky. While it is set, writes that try to set the open bit are ignored and the open bit reads 0. Only reset clears the lock, and after reset the open bit is writable again.
- R5: While locked, the global enable bit, the size code and the segment enable bit keep their values whatever is written. The closed bit stays writable.
- R6: Size codes 00, 01 and 10 select 1 MB, 2 MB and 8 MB. The segment base is the installed RAM size minus the selected size, and the segment ends at the top of RAM.
- R7: Size code 11 selects the size in MB given on `ext_size_mb`. That input is sampled only while `rst` is high, so later changes to it have no effect until the next reset.
- R8: A non-SMM access inside the segment is blocked (`mem_block`=1) when the global enable and segment enable are set and the open bit is 0. A blocked read drives `mem_rdata`=0xFF, and a blocked write drives `mem_rdata`=0x00 and must be discarded.
- R9: An access below the segment base, or at or above the top of RAM, is passed through (`mem_block`=0, `mem_rdata`=0x00).
- R10: An access in system-management mode always passes through. So does any access when the open bit is 1 or when either enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| ext_size_mb | input | EXT_W | Extended segment size in MB, sampled during reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_sel | input | 1 | Register select: 0 main control, 1 extended control |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Readback of the selected register |
| mem_addr | input | ADDR_W | Byte address of the checked access |
| mem_smm | input | 1 | Access is made in system-management mode |
| mem_wr | input | 1 | 1 = write, 0 = read |
| mem_block | output | 1 | Access is blocked; 0 means pass through |
| mem_rdata | output | 8 | Forced read data (0xFF on a blocked read) |

## Verification
Some properties are checked on every cycle. The lock must stay set once set. The open bit must never be high while locked. The frozen fields must not change across a locked cycle. SMM accesses and accesses above RAM must never be blocked. A blocked read must always return 0xFF. Only the bench scenarios can show the remaining behaviour: the exact window boundary for each size code, the extended size being captured at reset and then ignored, and the open bit becoming writable again after a reset releases the lock.

// File: rtl/smg_pkg.sv
package smg_pkg;

    localparam int MB_SHIFT = 20;

    typedef enum logic [1:0] {
        SEG_1MB = 2'b00,
        SEG_2MB = 2'b01,
        SEG_8MB = 2'b10,
        SEG_EXT = 2'b11
    } seg_size_e;

    typedef struct packed {
        logic open;
        logic closed;
        logic lock;
        logic gen;
    } smram_ctl_t;

    typedef struct packed {
        seg_size_e size;
        logic      seg_en;
    } ext_ctl_t;

    function automatic smram_ctl_t unpack_main(input logic [7:0] b);
        smram_ctl_t c;
        c.open   = b[6];
        c.closed = b[5];
        c.lock   = b[4];
        c.gen    = b[3];
        return c;
    endfunction

    function automatic logic [7:0] pack_main(input smram_ctl_t c);
        return {1'b0, c.open, c.closed, c.lock, c.gen, 3'b000};
    endfunction

    function automatic ext_ctl_t unpack_ext(input logic [7:0] b);
        ext_ctl_t e;
        e.size   = seg_size_e'(b[2:1]);
        e.seg_en = b[0];
        return e;
    endfunction

    function automatic logic [7:0] pack_ext(input ext_ctl_t e);
        return {5'b00000, e.size, e.seg_en};
    endfunction

endpackage

// File: rtl/smg_cfg_regs.sv
module smg_cfg_regs
    import smg_pkg::*;
#(
    parameter int EXT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [EXT_W-1:0] ext_size_in,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    output smram_ctl_t       smram_q,
    output ext_ctl_t         ext_q,
    output logic [EXT_W-1:0] ext_mb_q
);

    smram_ctl_t wr_main;
    ext_ctl_t   wr_ext;

    always_comb begin
        wr_main = unpack_main(cfg_wdata);
        wr_ext  = unpack_ext(cfg_wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            smram_q  <= '0;
            ext_q    <= '{size: SEG_1MB, seg_en: 1'b0};
            ext_mb_q <= ext_size_in;
        end else if (cfg_we) begin
            if (!cfg_sel) begin
                smram_q.closed <= wr_main.closed;
                if (!smram_q.lock) begin
                    smram_q.gen  <= wr_main.gen;
                    smram_q.lock <= wr_main.lock;
                    smram_q.open <= wr_main.open & ~wr_main.lock;
                end
            end else if (!smram_q.lock) begin
                ext_q <= wr_ext;
            end
        end
    end

    assign cfg_rdata = cfg_sel ? pack_ext(ext_q) : pack_main(smram_q);

endmodule

// File: rtl/smg_seg_window.sv
module smg_seg_window
    import smg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int RAM_MB = 128,
    parameter int EXT_W  = 8
) (
    input  ext_ctl_t          ext_q,
    input  logic [EXT_W-1:0]  ext_mb_q,
    output logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] top_addr
);

    localparam int MB_W = ADDR_W - MB_SHIFT;
    localparam logic [MB_W-1:0] RAM_MB_V = MB_W'(RAM_MB);

    logic [MB_W-1:0] size_mb;
    logic [MB_W-1:0] base_mb;

    always_comb begin
        unique case (ext_q.size)
            SEG_1MB: size_mb = MB_W'(1);
            SEG_2MB: size_mb = MB_W'(2);
            SEG_8MB: size_mb = MB_W'(8);
            default: size_mb = MB_W'(ext_mb_q);
        endcase
        base_mb = (size_mb >= RAM_MB_V) ? '0 : (RAM_MB_V - size_mb);
    end

    assign base_addr = {base_mb, {MB_SHIFT{1'b0}}};
    assign top_addr  = {RAM_MB_V, {MB_SHIFT{1'b0}}};

endmodule

// File: rtl/smg_access_filter.sv
module smg_access_filter
    import smg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_smm,
    input  logic              mem_wr,
    input  smram_ctl_t        smram_q,
    input  ext_ctl_t          ext_q,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] top_addr,
    output logic              mem_block,
    output logic [7:0]        mem_rdata
);

    logic in_seg;
    logic guarded;

    always_comb begin
        in_seg    = (mem_addr >= base_addr) && (mem_addr < top_addr);
        guarded   = smram_q.gen && ext_q.seg_en && !smram_q.open;
        mem_block = in_seg && guarded && !mem_smm;
        mem_rdata = (mem_block && !mem_wr) ? 8'hFF : 8'h00;
    end

endmodule

// File: rtl/smram_guard.sv
module smram_guard
    import smg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int RAM_MB = 128,
    parameter int EXT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [EXT_W-1:0]  ext_size_mb,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_smm,
    input  logic              mem_wr,
    output logic              mem_block,
    output logic [7:0]        mem_rdata
);

    smram_ctl_t        smram_q;
    ext_ctl_t          ext_q;
    logic [EXT_W-1:0]  ext_mb_q;
    logic [ADDR_W-1:0] base_addr;
    logic [ADDR_W-1:0] top_addr;

    smg_cfg_regs #(.EXT_W(EXT_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .ext_size_in (ext_size_mb),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .smram_q     (smram_q),
        .ext_q       (ext_q),
        .ext_mb_q    (ext_mb_q)
    );

    smg_seg_window #(.ADDR_W(ADDR_W), .RAM_MB(RAM_MB), .EXT_W(EXT_W)) u_win (
        .ext_q     (ext_q),
        .ext_mb_q  (ext_mb_q),
        .base_addr (base_addr),
        .top_addr  (top_addr)
    );

    smg_access_filter #(.ADDR_W(ADDR_W)) u_filt (
        .mem_addr  (mem_addr),
        .mem_smm   (mem_smm),
        .mem_wr    (mem_wr),
        .smram_q   (smram_q),
        .ext_q     (ext_q),
        .base_addr (base_addr),
        .top_addr  (top_addr),
        .mem_block (mem_block),
        .mem_rdata (mem_rdata)
    );

endmodule

// File: rtl/smram_guard_chk.sv
module smram_guard_chk
    import smg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int RAM_MB = 128
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic              cfg_sel,
    input logic [7:0]        cfg_wdata,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_smm,
    input logic              mem_wr,
    input logic              mem_block,
    input logic [7:0]        mem_rdata,
    input smram_ctl_t        smram_q,
    input ext_ctl_t          ext_q
);

    localparam logic [ADDR_W:0] RAM_BYTES = (ADDR_W+1)'(RAM_MB) << MB_SHIFT;

    assert_open_write_R2: assert property (@(posedge clk) disable iff (rst)
        (!smram_q.lock && cfg_we && !cfg_sel && !cfg_wdata[4])
        |=> (smram_q.open == $past(cfg_wdata[6])));

    assert_lock_no_open_R3: assert property (@(posedge clk) disable iff (rst)
        smram_q.lock |-> !smram_q.open);

    assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        smram_q.lock |=> smram_q.lock);

    assert_fields_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        smram_q.lock |=> ($stable(smram_q.gen) && $stable(ext_q)));

    assert_blocked_read_ff_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_block && !mem_wr) |-> (mem_rdata == 8'hFF));

    assert_above_ram_pass_R9: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, mem_addr} >= RAM_BYTES) |-> !mem_block);

    assert_smm_pass_R10: assert property (@(posedge clk) disable iff (rst)
        mem_smm |-> !mem_block);

endmodule

bind smram_guard smram_guard_chk #(.ADDR_W(ADDR_W), .RAM_MB(RAM_MB)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .mem_addr  (mem_addr),
    .mem_smm   (mem_smm),
    .mem_wr    (mem_wr),
    .mem_block (mem_block),
    .mem_rdata (mem_rdata),
    .smram_q   (smram_q),
    .ext_q     (ext_q)
);

// File: tb/smram_guard_bench.sv
module smram_guard_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int EXT_W  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [EXT_W-1:0]  ext_size_mb = 8'd16;
    logic              cfg_we = 1'b0;
    logic              cfg_sel = 1'b0;
    logic [7:0]        cfg_wdata = 8'h00;
    logic [7:0]        cfg_rdata;
    logic [ADDR_W-1:0] mem_addr = '0;
    logic              mem_smm = 1'b0;
    logic              mem_wr = 1'b0;
    logic              mem_block;
    logic [7:0]        mem_rdata;

    smram_guard #(.ADDR_W(ADDR_W), .RAM_MB(128), .EXT_W(EXT_W)) u_smram_guard (
        .clk(clk), .rst(rst), .ext_size_mb(ext_size_mb),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_addr(mem_addr), .mem_smm(mem_smm), .mem_wr(mem_wr),
        .mem_block(mem_block), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        string      rid;
        logic [8:0] exp;
        bit         is_mem;
    } sb_item_t;

    sb_item_t sb[$];
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            sb_item_t it;
            logic [8:0] act;
            wait (sb.size() != 0);
            it = sb.pop_front();
            act = it.is_mem ? {mem_block, mem_rdata} : {1'b0, cfg_rdata};
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual 0x%03h expected 0x%03h", it.rid, act, it.exp);
            end
        end
    end

    task automatic push(input string rid, input logic [8:0] exp, input bit is_mem);
        sb_item_t it;
        it.rid = rid; it.exp = exp; it.is_mem = is_mem;
        sb.push_back(it);
        wait (sb.size() == 0);
        #1;
    endtask

    task automatic do_reset(input logic [EXT_W-1:0] ext);
        @(negedge clk);
        rst = 1'b1;
        ext_size_mb = ext;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cfg_write(input logic sel, input logic [7:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic expect_cfg(input logic sel, input logic [7:0] exp, input string rid);
        cfg_sel = sel;
        #1;
        push(rid, {1'b0, exp}, 1'b0);
    endtask

    task automatic expect_mem(input logic [ADDR_W-1:0] a, input logic smm, input logic wr,
                              input logic [8:0] exp, input string rid);
        mem_addr = a; mem_smm = smm; mem_wr = wr;
        #1;
        push(rid, exp, 1'b1);
    endtask

    localparam logic [8:0] PASS   = 9'h000;
    localparam logic [8:0] BLK_RD = 9'h1FF;
    localparam logic [8:0] BLK_WR = 9'h100;

    initial begin
        do_reset(8'd16);
        expect_cfg(1'b0, 8'h00, "R1 main reset");
        expect_cfg(1'b1, 8'h00, "R1 ext reset");

        cfg_write(1'b0, 8'h40); expect_cfg(1'b0, 8'h40, "R2 set open");
        cfg_write(1'b0, 8'h00); expect_cfg(1'b0, 8'h00, "R2 clear open");

        // 1 MB segment, enabled and closed
        cfg_write(1'b1, 8'h01); expect_cfg(1'b1, 8'h01, "R1 ext readback");
        cfg_write(1'b0, 8'h28); expect_cfg(1'b0, 8'h28, "R1 main readback");
        expect_mem(32'h07F0_0000, 1'b0, 1'b0, BLK_RD, "R8 1MB base read");
        expect_mem(32'h07F0_0000, 1'b0, 1'b1, BLK_WR, "R8 1MB base write");
        expect_mem(32'h07FF_FFFF, 1'b0, 1'b0, BLK_RD, "R8 top byte read");
        expect_mem(32'h07EF_FFFF, 1'b0, 1'b0, PASS,   "R9 below 1MB base read");
        expect_mem(32'h07EF_FFFF, 1'b0, 1'b1, PASS,   "R9 below 1MB base write");
        expect_mem(32'h0800_0000, 1'b0, 1'b0, PASS,   "R9 above RAM");
        expect_mem(32'h07F0_0000, 1'b1, 1'b0, PASS,   "R10 SMM read");
        expect_mem(32'h07F0_0000, 1'b1, 1'b1, PASS,   "R10 SMM write");

        // R6 2 MB and 8 MB
        cfg_write(1'b1, 8'h03);
        expect_mem(32'h07E0_0000, 1'b0, 1'b0, BLK_RD, "R6 2MB base");
        expect_mem(32'h07DF_FFFF, 1'b0, 1'b0, PASS,   "R6 below 2MB base");
        cfg_write(1'b1, 8'h05);
        expect_mem(32'h0780_0000, 1'b0, 1'b0, BLK_RD, "R6 8MB base");
        expect_mem(32'h077F_FFFF, 1'b0, 1'b0, PASS,   "R6 below 8MB base");

        // R7 extended size 16 MB
        cfg_write(1'b1, 8'h07);
        expect_mem(32'h0700_0000, 1'b0, 1'b0, BLK_RD, "R7 ext16 base");
        expect_mem(32'h06FF_FFFF, 1'b0, 1'b0, PASS,   "R7 below ext16 base");
        ext_size_mb = 8'd32;
        expect_mem(32'h06FF_FFFF, 1'b0, 1'b0, PASS,   "R7 live input ignored");

        // R10 open or disabled -> pass
        cfg_write(1'b0, 8'h68);
        expect_mem(32'h0700_0000, 1'b0, 1'b0, PASS,   "R10 open passes");
        cfg_write(1'b0, 8'h28);
        cfg_write(1'b1, 8'h06);
        expect_mem(32'h0700_0000, 1'b0, 1'b0, PASS,   "R10 seg disabled");
        cfg_write(1'b1, 8'h07);

        // lock with open requested
        cfg_write(1'b0, 8'h78); expect_cfg(1'b0, 8'h38, "R3 lock clears open");
        cfg_write(1'b0, 8'h48); expect_cfg(1'b0, 8'h18, "R4 open ignored, R5 gen kept");
        cfg_write(1'b0, 8'h00); expect_cfg(1'b0, 8'h18, "R4 lock sticky");
        cfg_write(1'b1, 8'h00); expect_cfg(1'b1, 8'h07, "R5 ext frozen");
        expect_mem(32'h0700_0000, 1'b0, 1'b0, BLK_RD, "R5 window kept");

        // reset releases lock, new ext size captured
        do_reset(8'd4);
        expect_cfg(1'b0, 8'h00, "R4 reset clears lock");
        cfg_write(1'b0, 8'h40); expect_cfg(1'b0, 8'h40, "R4 open writable again");
        cfg_write(1'b1, 8'h07);
        cfg_write(1'b0, 8'h28);
        expect_mem(32'h07C0_0000, 1'b0, 1'b0, BLK_RD, "R7 ext4 base");
        expect_mem(32'h07BF_FFFF, 1'b0, 1'b0, PASS,   "R7 below ext4 base");

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule